// File: doc/BRIEF.md
# Write-Once Timing Tick Divider

This block turns a free-running oscillator into a slow, evenly spaced timing tick for a non-volatile memory controller that paces its program and erase steps by that tick. Software sets the division once, through an 8-bit control register on a small register bus. That register holds three things: an enable for a fixed divide-by-8 prescaler, a 6-bit divide field, and a read-only flag that reports whether the register has been loaded. The intended tick rate lies between 150 and 200 kHz, and the largest overall ratio is 512.

After reset, the first write to the control register takes effect and locks the configuration. Every later write is dropped until the next reset. The tick stays silent while the register is unloaded, so downstream timing cannot start on an unconfigured divider. Two reserved locations next to the control register always read zero and absorb writes. The asynchronous reset input is released through a two-stage synchronizer, so the first write that can take effect lands on the third rising edge after release.

Top module: `memtick_clkgen`

## Requirements
- R1: After reset, the control register reads 0x00 at address 0, `loaded_o` is 0 and `tick_o` is 0.
- R2: The first write to address 0 after reset stores write-data bits 6:0 and sets the loaded flag on the same clock edge. Address 0 reads `{1'b1, wdata[6:0]}` in the next cycle.
- R3: Once the flag is set, writes to address 0 change neither the stored bits 6:0 nor the flag until the next reset.
- R4: Bit 7 of the read data is the loaded flag. Write-data bit 7 is never stored, so writing 0x00 reads back as 0x80 and writing 0x85 reads back as 0x85.
- R5: Addresses 1, 2 and 3 always read 0x00. Writes to them leave the control register and the loaded flag unchanged.
- R6: `tick_o` is 0 in every cycle in which the loaded flag is 0.
- R7: With bit 6 clear and divide field N (bits 5:0), the ratio is N+1. Counting c = 0 from the first cycle after the loading edge, `tick_o` is a one-cycle pulse exactly when c mod (N+1) = N. With N = 0, the tick is high in every cycle.
- R8: With bit 6 set, the ratio is 8·(N+1). `tick_o` is high exactly when c mod 8(N+1) = 8(N+1)−1. A field of 63 gives the maximum ratio of 512.
- R9: A new reset returns the block to the unloaded state, and a fresh first write is accepted afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 2 | Register address: 0 control, 1 to 3 reserved |
| bus_wr_i | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register, combinational |
| loaded_o | output | 1 | Configuration loaded flag |
| tick_o | output | 1 | Divided timing tick, one clock wide |

## Verification
A write is sampled on a rising edge. The read data and the loaded flag show the result from that edge on, so they are compared at the falling edge that follows, half a cycle later. The tick is combinational from the counters, which leave zero on the first edge after the loading edge. The reference model therefore numbers cycles from the loading edge and predicts the tick at the falling edge of every cycle. Stimulus changes just after a rising edge, and every comparison happens at the falling edge, so each expected value refers to a state that has already settled.

// File: rtl/memtick_pkg.sv
package memtick_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned FIELD_W = 6;

  typedef struct packed {
    logic                 pre_en;
    logic [FIELD_W-1:0]   div_n;
  } memtick_cfg_t;
endpackage

// File: rtl/memtick_cfg_reg.sv
module memtick_cfg_reg
  import memtick_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_hit_i,
  input  memtick_cfg_t wr_cfg_i,
  output memtick_cfg_t cfg_o,
  output logic         loaded_o
);
  memtick_cfg_t cfg_q, cfg_d;
  logic         loaded_q, loaded_d;
  logic         take;

  always_comb begin
    take     = wr_hit_i & ~loaded_q;
    cfg_d    = cfg_q;
    loaded_d = loaded_q;
    if (take) begin
      cfg_d    = wr_cfg_i;
      loaded_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      loaded_q <= 1'b0;
    end else begin
      cfg_q    <= cfg_d;
      loaded_q <= loaded_d;
    end
  end

  assign cfg_o    = cfg_q;
  assign loaded_o = loaded_q;

  assert_cfg_locked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loaded_q |=> ($stable(cfg_q) && loaded_q));

  assert_load_by_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(loaded_q) |-> ($past(wr_hit_i) && cfg_q == $past(wr_cfg_i)));
endmodule

// File: rtl/memtick_prescale.sv
module memtick_prescale #(
  parameter int unsigned RATIO = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic en_i,
  output logic wrap_o
);
  localparam int unsigned CNT_W = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RATIO - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i || !en_i) begin
      cnt_d = '0;
    end else if (at_last) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign wrap_o = en_i ? at_last : 1'b1;

  assert_pre_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/memtick_divider.sv
module memtick_divider #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_limit;

  assign at_limit = (cnt_q == limit_i);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i) begin
      cnt_d = '0;
    end else if (step_i) begin
      cnt_d = at_limit ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign wrap_o = at_limit;

  assert_cnt_in_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= limit_i));
endmodule

// File: rtl/memtick_clkgen.sv
module memtick_clkgen
  import memtick_pkg::*;
#(
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned PRE_RATIO = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  output logic              loaded_o,
  output logic              tick_o
);
  localparam logic [ADDR_W-1:0] CTRL_SEL = ADDR_W'(CTRL_ADDR);

  logic         sync1_q, sync2_q, rst_n;
  logic         ctrl_sel, wr_hit;
  memtick_cfg_t wr_cfg, cfg;
  logic         loaded, pre_wrap, div_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= 1'b1;
      sync2_q <= sync1_q;
    end
  end
  assign rst_n = sync2_q;

  assign ctrl_sel = (bus_addr_i == CTRL_SEL);
  assign wr_hit   = bus_wr_i & ctrl_sel;
  assign wr_cfg   = memtick_cfg_t'(bus_wdata_i[REG_W-2:0]);

  memtick_cfg_reg u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .wr_hit_i (wr_hit),
    .wr_cfg_i (wr_cfg),
    .cfg_o    (cfg),
    .loaded_o (loaded)
  );

  memtick_prescale #(.RATIO(PRE_RATIO)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .run_i  (loaded),
    .en_i   (cfg.pre_en),
    .wrap_o (pre_wrap)
  );

  memtick_divider #(.CNT_W(FIELD_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .run_i   (loaded),
    .step_i  (pre_wrap),
    .limit_i (cfg.div_n),
    .wrap_o  (div_wrap)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (ctrl_sel) bus_rdata_o = {loaded, cfg};
  end

  assign loaded_o = loaded;
  assign tick_o   = loaded & pre_wrap & div_wrap;

  assert_tick_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    tick_o |-> loaded_o);

  assert_reserved_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_wr_i && !ctrl_sel && !loaded_o) |=> !loaded_o);

  assert_tick_single_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tick_o && cfg.div_n != '0) |=> !tick_o);
endmodule

// File: tb/test_memtick_clkgen.sv
`timescale 1ns/1ps
module test_memtick_clkgen;
  localparam time CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       loaded, tick;

  int n_cmp = 0;
  int n_bad = 0;
  string phase_tag = "R1";

  // reference model state
  int  m_sync = 0;
  bit  m_loaded = 0;
  int  m_cfg = 0;
  int  m_c = 0;

  memtick_clkgen i_memtick_clkgen (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .loaded_o(loaded), .tick_o(tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 0; m_loaded = 0; m_cfg = 0; m_c = 0;
    end else if (m_sync < 2) begin
      m_sync++;
    end else if (m_loaded) begin
      m_c++;
    end else if (wr && addr == 2'd0) begin
      m_loaded = 1; m_cfg = wdata & 8'h7f; m_c = 0;
    end
  end

  function automatic int ratio();
    int r = (m_cfg & 8'h3f) + 1;
    if (m_cfg & 8'h40) r = r * 8;
    return r;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && m_sync == 2) begin
      int exp_rd, exp_tick;
      exp_rd   = (addr == 2'd0) ? ((m_loaded ? 8'h80 : 8'h00) | m_cfg) : 0;
      exp_tick = (m_loaded && (m_c % ratio()) == ratio() - 1) ? 1 : 0;
      check((addr != 2'd0) ? "R5" : phase_tag, rdata, exp_rd);
      check(phase_tag, loaded, m_loaded);
      check(!m_loaded ? "R6" : ((m_cfg & 8'h40) ? "R8" : "R7"), tick, exp_tick);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; wr = 1'b0; addr = 2'd0;
    step(3);
    rst_n = 1'b1;
    step(3);
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    step(1);
    wr = 1'b0; addr = 2'd0;
  endtask

  task automatic peek(logic [1:0] a, string tag, int exp);
    addr = a;
    @(negedge clk);
    check(tag, rdata, exp);
    step(1);
    addr = 2'd0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    phase_tag = "R1";
    do_reset();
    @(negedge clk);
    check("R1", rdata, 0); check("R1", loaded, 0); check("R1", tick, 0);
    phase_tag = "R6"; step(5);
    // reserved locations absorb writes
    phase_tag = "R5";
    bus_write(2'd1, 8'hff); bus_write(2'd2, 8'h7f); bus_write(2'd3, 8'h41);
    peek(2'd1, "R5", 0); peek(2'd2, "R5", 0); peek(2'd3, "R5", 0);
    peek(2'd0, "R5", 0);
    // first write: N=0, no prescaler, bit7 written as 0
    phase_tag = "R2";
    bus_write(2'd0, 8'h00);
    @(negedge clk); check("R4", rdata, 8'h80); check("R2", loaded, 1);
    phase_tag = "R7"; step(10);
    phase_tag = "R3";
    bus_write(2'd0, 8'h45); bus_write(2'd0, 8'hff);
    peek(2'd0, "R3", 8'h80); step(5);
    // R9: reset unlocks, N=5 without prescaler, bit7 written as 1
    do_reset();
    @(negedge clk); check("R9", rdata, 0); check("R9", loaded, 0);
    phase_tag = "R4"; bus_write(2'd0, 8'h85);
    peek(2'd0, "R4", 8'h85);
    phase_tag = "R7"; step(40);
    // prescaler on, N=2 -> ratio 24
    do_reset();
    phase_tag = "R8"; bus_write(2'd0, 8'h42); step(100);
    // maximum ratio 512
    do_reset();
    phase_tag = "R8"; bus_write(2'd0, 8'h7f); step(1100);
    phase_tag = "R3"; bus_write(2'd0, 8'h01); peek(2'd0, "R3", 8'hff); step(20);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule